// File: doc/BRIEF.md
# Iterative Decoder Convergence Checker

This block sits beside the outer soft-in/soft-out decoder of an iterative decoder built from serially concatenated codes. Each decoder iteration streams the codeword through it, one information position per beat. Each beat carries the soft value of the information bit and the two extrinsic soft values that the outer decoder produced for the two coded bits at that position. The block slices every soft value to a hard decision. It re-encodes the information decisions with a two-state, rate-1/2 outer code whose generator on each output is (1+D), with tail-biting, and checks each re-encoded bit against the matching extrinsic decision.

One cycle after the last beat of an iteration, the block gives its verdict. The word has converged if no bit disagreed anywhere in the iteration. The iteration budget is spent if the iteration count has reached a programmable cap, normally 32. Decoding stops if either holds. The controller in front of the decoder uses this verdict to end decoding early, which cuts the average iteration count well below the cap without losing error-rate performance.

Top module: `conv_stop_chk`

## Requirements
- R1: A soft value, taken as two's complement, maps to hard decision 1 when it is zero or negative and to 0 when it is positive. This rule applies to the information input and to both extrinsic lanes.
- R2: For every beat i other than the first of the frame, both extrinsic decisions (lane 0 in bits [LLR_W-1:0], lane 1 in bits [2*LLR_W-1:LLR_W]) must equal d[i] XOR d[i-1]. Any disagreement on either lane makes the iteration non-converged.
- R3: The first beat's two extrinsic decisions are checked against d[0] XOR d[last]. This is the tail-biting wrap, and it is resolved when the last beat arrives.
- R4: In a frame of a single beat (first and last together), both extrinsic decisions are expected to be 0.
- R5: Disagreement is sticky within an iteration. A pulse on iter_start_i clears it, so a mismatch in one iteration does not affect the verdict of the next.
- R6: done_o is high for exactly one cycle, the cycle after the clock edge that samples the last beat. converged_o, limit_o, stop_o and stop_iter_o change only at that edge and hold until the next verdict.
- R7: iter_start_i with new_cw_i set makes the current iteration number 1. iter_start_i without new_cw_i adds 1 to it, saturating at the maximum of its width. stop_iter_o reports the number of the iteration that was judged.
- R8: limit_o is 1 when the judged iteration number is greater than or equal to max_iter_i. stop_o equals converged_o OR limit_o.
- R9: After reset, done_o, converged_o, limit_o, stop_o and stop_iter_o are all 0.
- R10: Cycles with beat_valid_i low between beats have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iter_start_i | input | 1 | Pulse that opens a new iteration |
| new_cw_i | input | 1 | With iter_start_i: first iteration of a new codeword |
| max_iter_i | input | ITER_W | Iteration cap |
| beat_valid_i | input | 1 | Beat carries one information position |
| beat_last_i | input | 1 | Beat is the last position of the frame |
| info_llr_i | input | LLR_W | Soft value of the information bit |
| ext_llr_i | input | 2*LLR_W | Extrinsic soft values of the two coded bits |
| done_o | output | 1 | Verdict pulse |
| converged_o | output | 1 | All re-encoded bits agreed |
| limit_o | output | 1 | Iteration cap reached |
| stop_o | output | 1 | Stop decoding |
| stop_iter_o | output | ITER_W | Iteration number that was judged |

## Verification
A stale previous-bit register or a lost head-of-frame value shows up as a wrong converged_o in the verdict of the very frame it corrupts. Frames with one flipped lane at the first, a middle and the last position each expose a different path. A mismatch flag that is not cleared shows as a false non-convergence one iteration later. A miscounted iteration shows on stop_iter_o and limit_o at the next verdict. Zero-valued soft inputs and single-beat frames catch errors in the slicer and in the wrap logic.

// File: rtl/conv_stop_pkg.sv
package conv_stop_pkg;
  localparam int unsigned CODE_LANES = 2;

  typedef struct packed {
    logic converged;
    logic limit;
  } verdict_t;
endpackage

// File: rtl/conv_stop_slicer.sv
module conv_stop_slicer #(
  parameter int unsigned LANES = 1,
  parameter int unsigned LLR_W = 6
) (
  input  logic [LANES*LLR_W-1:0] llr_i,
  output logic [LANES-1:0]       hd_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LLR_W-1:0] v;
    assign v       = llr_i[g*LLR_W +: LLR_W];
    // zero counts as a 1 decision
    assign hd_o[g] = v[LLR_W-1] | (v == '0);
  end
endmodule

// File: rtl/conv_stop_reenc.sv
module conv_stop_reenc
  import conv_stop_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  valid_i,
  input  logic                  last_i,
  input  logic                  info_i,
  input  logic [CODE_LANES-1:0] ext_i,
  output logic                  mm_nxt_o
);
  logic                  first_q, prev_q, head_d_q, mm_q;
  logic [CODE_LANES-1:0] head_e_q;
  logic                  eff_first, mid_mm, wrap_mm, beat_mm, wrap_d;
  logic [CODE_LANES-1:0] wrap_e;

  assign eff_first = first_q | clear_i;

  always_comb begin
    mid_mm   = !eff_first && (ext_i != {CODE_LANES{info_i ^ prev_q}});
    wrap_d   = eff_first ? info_i : head_d_q;
    wrap_e   = eff_first ? ext_i  : head_e_q;
    wrap_mm  = last_i && (wrap_e != {CODE_LANES{wrap_d ^ info_i}});
    beat_mm  = valid_i && (mid_mm || wrap_mm);
    mm_nxt_o = (clear_i ? 1'b0 : mm_q) | beat_mm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= 1'b1;
      prev_q   <= 1'b0;
      head_d_q <= 1'b0;
      head_e_q <= '0;
      mm_q     <= 1'b0;
    end else begin
      mm_q <= mm_nxt_o;
      if (clear_i) first_q <= 1'b1;
      if (valid_i) begin
        first_q <= last_i;
        prev_q  <= info_i;
        if (eff_first) begin
          head_d_q <= info_i;
          head_e_q <= ext_i;
        end
      end
    end
  end

  AST_CLEAR_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !valid_i |=> !mm_q); // R5
  AST_MM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_q && !clear_i |=> mm_q); // R5
endmodule

// File: rtl/conv_stop_iter.sv
module conv_stop_iter #(
  parameter int unsigned ITER_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              new_cw_i,
  input  logic [ITER_W-1:0] max_i,
  output logic [ITER_W-1:0] cnt_nxt_o,
  output logic              limit_nxt_o
);
  localparam logic [ITER_W-1:0] CNT_TOP = '1;
  localparam logic [ITER_W-1:0] CNT_ONE = ITER_W'(1);

  logic [ITER_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (start_i) begin
      if (new_cw_i)             cnt_nxt_o = CNT_ONE;
      else if (cnt_q != CNT_TOP) cnt_nxt_o = cnt_q + CNT_ONE;
    end
    limit_nxt_o = (cnt_nxt_o >= max_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  AST_FIRST_ITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && new_cw_i |=> cnt_q == CNT_ONE); // R7
  AST_ITER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !new_cw_i && cnt_q != CNT_TOP |=> cnt_q == $past(cnt_q) + CNT_ONE); // R7
endmodule

// File: rtl/conv_stop_chk.sv
module conv_stop_chk
  import conv_stop_pkg::*;
#(
  parameter int unsigned LLR_W    = 6,
  parameter int unsigned MAX_ITER = 32,
  localparam int unsigned ITER_W  = $clog2(MAX_ITER + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        iter_start_i,
  input  logic                        new_cw_i,
  input  logic [ITER_W-1:0]           max_iter_i,
  input  logic                        beat_valid_i,
  input  logic                        beat_last_i,
  input  logic [LLR_W-1:0]            info_llr_i,
  input  logic [CODE_LANES*LLR_W-1:0] ext_llr_i,
  output logic                        done_o,
  output logic                        converged_o,
  output logic                        limit_o,
  output logic                        stop_o,
  output logic [ITER_W-1:0]           stop_iter_o
);
  logic                  info_hd, mm_nxt, limit_nxt;
  logic [CODE_LANES-1:0] ext_hd;
  logic [ITER_W-1:0]     cnt_nxt;
  logic                  done_q;
  verdict_t              verdict_q;
  logic [ITER_W-1:0]     iter_q;
  logic                  decide;

  conv_stop_slicer #(.LANES(1), .LLR_W(LLR_W)) u_info_slice (
    .llr_i(info_llr_i), .hd_o(info_hd));

  conv_stop_slicer #(.LANES(CODE_LANES), .LLR_W(LLR_W)) u_ext_slice (
    .llr_i(ext_llr_i), .hd_o(ext_hd));

  conv_stop_reenc u_reenc (
    .clk_i, .rst_ni,
    .clear_i (iter_start_i),
    .valid_i (beat_valid_i),
    .last_i  (beat_last_i),
    .info_i  (info_hd),
    .ext_i   (ext_hd),
    .mm_nxt_o(mm_nxt));

  conv_stop_iter #(.ITER_W(ITER_W)) u_iter (
    .clk_i, .rst_ni,
    .start_i    (iter_start_i),
    .new_cw_i   (new_cw_i),
    .max_i      (max_iter_i),
    .cnt_nxt_o  (cnt_nxt),
    .limit_nxt_o(limit_nxt));

  assign decide = beat_valid_i & beat_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      verdict_q <= '0;
      iter_q    <= '0;
    end else begin
      done_q <= decide;
      if (decide) begin
        verdict_q.converged <= !mm_nxt;
        verdict_q.limit     <= limit_nxt;
        iter_q              <= cnt_nxt;
      end
    end
  end

  assign done_o      = done_q;
  assign converged_o = verdict_q.converged;
  assign limit_o     = verdict_q.limit;
  assign stop_o      = verdict_q.converged | verdict_q.limit;
  assign stop_iter_o = iter_q;

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide |=> done_o); // R6
  AST_DONE_ONLY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decide |=> !done_o); // R6
  AST_VERDICT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decide |=> $stable(stop_o) && $stable(stop_iter_o)); // R6
endmodule

// File: tb/conv_stop_chk_tb.sv
module conv_stop_chk_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LLR_W = 6;
  localparam int ITER_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic iter_start_i = 1'b0, new_cw_i = 1'b0;
  logic [ITER_W-1:0] max_iter_i = '0;
  logic beat_valid_i = 1'b0, beat_last_i = 1'b0;
  logic [LLR_W-1:0] info_llr_i = '0;
  logic [2*LLR_W-1:0] ext_llr_i = '0;
  logic done_o, converged_o, limit_o, stop_o;
  logic [ITER_W-1:0] stop_iter_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_stop_chk u_dut (
    .clk_i(clk), .rst_ni, .iter_start_i, .new_cw_i, .max_iter_i,
    .beat_valid_i, .beat_last_i, .info_llr_i, .ext_llr_i,
    .done_o, .converged_o, .limit_o, .stop_o, .stop_iter_o);

  typedef struct { bit conv; bit lim; int it; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  int exp_cnt = 0;
  logic [31:0] rng = 32'h1D2C3B4A;
  bit prev_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [LLR_W-1:0] mk(input logic b, input bit z, input int m);
    logic [LLR_W-1:0] mag;
    mag = LLR_W'((m % 20) + 1);
    return b ? (z ? '0 : -mag) : mag;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // R1 R2 R3 R4: expected verdict computed from decisions and flips
  task automatic run_iter(input bit new_cw, input int n, input logic [15:0] d,
                          input logic [15:0] f0, input logic [15:0] f1,
                          input int maxit, input bit gaps, input bit zmode);
    exp_t e;
    logic [15:0] mask;
    mask = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    exp_cnt = new_cw ? 1 : (exp_cnt < 63 ? exp_cnt + 1 : 63);
    e.conv = ((f0 | f1) & mask) == 16'h0;
    e.lim  = exp_cnt >= maxit;
    e.it   = exp_cnt;
    q.push_back(e);
    @(negedge clk);
    iter_start_i = 1'b1; new_cw_i = new_cw; max_iter_i = ITER_W'(maxit);
    @(negedge clk);
    iter_start_i = 1'b0; new_cw_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic code;
      code = d[i] ^ d[(i + n - 1) % n];
      beat_valid_i = 1'b1;
      beat_last_i  = (i == n - 1);
      info_llr_i   = mk(d[i], zmode, i + 3);
      ext_llr_i    = {mk(code ^ f1[i], zmode, i + 7), mk(code ^ f0[i], zmode, i * 5)};
      @(negedge clk);
      if (gaps && i != n - 1) begin
        beat_valid_i = 1'b0; beat_last_i = 1'b0;
        info_llr_i = ~info_llr_i; ext_llr_i = ~ext_llr_i;
        @(negedge clk);
      end
    end
    beat_valid_i = 1'b0; beat_last_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: R6 R7 R8
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done_o) begin
        chk(!prev_done, "R6 single-cycle done", 1, 0);
        if (q.size() == 0) chk(0, "R6 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(converged_o == e.conv, "R2/R3 converged", converged_o, e.conv);
          chk(limit_o == e.lim, "R8 limit", limit_o, e.lim);
          chk(stop_o == (e.conv | e.lim), "R8 stop", stop_o, e.conv | e.lim);
          chk(stop_iter_o == ITER_W'(e.it), "R7 stop_iter", stop_iter_o, e.it);
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o == 0 && converged_o == 0 && limit_o == 0 && stop_o == 0 && stop_iter_o == 0,
        "R9 reset outputs", {done_o, converged_o, limit_o, stop_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // clean frame, first iteration
    run_iter(1, 8, 16'h00B5, 0, 0, 32, 0, 0);
    // middle mismatch on lane 1 (R2)
    run_iter(1, 8, 16'h00B5, 0, 16'h0008, 32, 0, 0);
    // wrap mismatch on lane 0 (R3), second iteration
    run_iter(0, 8, 16'h0081, 16'h0001, 0, 32, 0, 0);
    // clean after mismatch (R5), third iteration
    run_iter(0, 8, 16'h0081, 0, 0, 32, 0, 0);
    // verdict holds (R6)
    repeat (3) @(negedge clk);
    chk(converged_o == 1 && stop_iter_o == 3 && done_o == 0, "R6 hold", stop_iter_o, 3);
    // last-position mismatch
    run_iter(0, 8, 16'h0081, 16'h0080, 0, 32, 0, 0);
    // single-beat frames (R4)
    run_iter(1, 1, 16'h0001, 0, 0, 32, 0, 0);
    run_iter(0, 1, 16'h0001, 0, 16'h0001, 32, 0, 0);
    // zero-valued soft inputs as decision 1 (R1)
    run_iter(1, 8, 16'h0055, 0, 0, 32, 0, 1);
    run_iter(0, 8, 16'h0055, 16'h0010, 0, 32, 0, 1);
    // idle gaps (R10)
    run_iter(1, 10, 16'h0326, 0, 0, 32, 1, 0);
    run_iter(0, 10, 16'h0326, 0, 16'h0200, 32, 1, 0);
    // limit reached (R8)
    run_iter(1, 6, 16'h002D, 16'h0004, 0, 3, 0, 0);
    run_iter(0, 6, 16'h002D, 16'h0004, 0, 3, 0, 0);
    run_iter(0, 6, 16'h002D, 16'h0004, 0, 3, 0, 0);
    run_iter(0, 6, 16'h002D, 0, 16'h0001, 3, 0, 0);
    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d, f0, f1;
      int n;
      rng = step(rng); d = rng[15:0]; n = int'(rng[19:16]) + 1;
      rng = step(rng); f0 = (rng[2:0] == 0) ? (16'h1 << rng[7:4]) : 16'h0;
      rng = step(rng); f1 = (rng[2:0] == 1) ? (16'h1 << rng[7:4]) : 16'h0;
      rng = step(rng);
      run_iter(rng[3:0] == 0, n, d, f0, f1, int'(rng[9:5]) + 1, rng[10], rng[11]);
    end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6 missing verdicts", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule